// File: doc/BRIEF.md
# Multi-Operand Fetch-And-Add Unit

This block is an atomic prefix-sum functional unit holding a small file of base registers. In any cycle, each of several thread ports may present an increment together with the index of a base register. Every port that issues a request gets back the base value it observed. The addressed base then moves forward by the sum of all increments aimed at it in that cycle. When several ports target one base in the same cycle, their requests merge into a single multi-operand operation. The lowest-numbered port sees the untouched base. Each higher port sees the base plus the increments of the lower-numbered ports on that base.

Software can load a base directly with a write strobe. A write and increments to the same base in one cycle are resolved write-first. Results come back exactly one cycle after the request, with a valid bit per port, and the unit never stalls. When every increment is one, the values returned to the ports are distinct and consecutive. This is the form needed to hand out compaction slots.

Top module: `mfa_unit`

## Requirements
- R1: After reset every base register reads as zero and every rspValid bit is low.
- R2: rspValid[i] equals reqValid[i] of the previous cycle; the unit accepts requests on every cycle without stalling.
- R3: A lone request returns the base's old value one cycle later, and the base then holds the old value plus the increment.
- R4: Among valid requests to the same base in one cycle, port i receives the base plus the sum of increments of all valid lower-numbered ports on that base (ascending port order).
- R5: After a cycle of requests, the base holds its prior value plus the sum of every valid increment aimed at it.
- R6: Requests to different bases in the same cycle do not affect each other's results or bases.
- R7: A base write in the same cycle as increments to that base is applied first; the increments and returned values build on the written value. A write alone sets the base.
- R8: A port with reqValid low contributes nothing to any base, even with a nonzero increment, and its rspData keeps its previous value.
- R9: All base arithmetic wraps modulo 2^DATA_W.
- R10: With all increments equal to one on a shared base, the returned values are consecutive integers, one per port in ascending port order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | PORTS | Per-port request strobe |
| reqBase | input | PORTS*IDX_W | Per-port base index, port i at bits [i*IDX_W +: IDX_W] |
| reqInc | input | PORTS*DATA_W | Per-port increment, port i at bits [i*DATA_W +: DATA_W] |
| wrEn | input | 1 | Base write strobe |
| wrBase | input | IDX_W | Index of the base to write |
| wrData | input | DATA_W | Value to load into the base |
| rspValid | output | PORTS | Per-port result valid, one cycle after the request |
| rspData | output | PORTS*DATA_W | Per-port observed base value, port i at bits [i*DATA_W +: DATA_W] |

## Verification
The bench sweeps every assignment of four ports to four bases, under every valid mask. It mixes in base writes, so it reaches each overlap of shared bases, idle ports and write collisions. A design that ordered ports the wrong way would hand the untouched base to the highest port. A design that summed invalid ports would drift the base; the bench catches this when it reads the base back. Directed cases check three more errors. A read-before-write design would return the stale base on a write collision. A design that did not wrap would show mismatches at the all-ones boundary. One that cleared idle outputs would break the hold rule.

// File: rtl/mfa_pkg.sv
package mfa_pkg;
  localparam int unsigned PORTS  = 4;
  localparam int unsigned BASES  = 4;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned IDX_W  = (BASES > 1) ? $clog2(BASES) : 1;

  // strobes from control to datapath
  typedef struct packed {
    logic [PORTS-1:0][PORTS-1:0] chainMask; // [i][j]: port j feeds port i prefix
    logic [BASES-1:0][PORTS-1:0] sumMask;   // [b][j]: port j adds into base b
    logic [BASES-1:0]            wrSel;     // base b overwritten this cycle
    logic [PORTS-1:0]            rspLoad;   // capture result for port i
  } strobe_t;
endpackage

// File: rtl/mfa_ctrl.sv
module mfa_ctrl
  import mfa_pkg::*;
(
  input  logic [PORTS-1:0]            reqValid,
  input  logic [PORTS-1:0][IDX_W-1:0] reqBase,
  input  logic                        wrEn,
  input  logic [IDX_W-1:0]            wrBase,
  output strobe_t                     strb
);
  always_comb begin
    strb = '0;
    for (int i = 0; i < PORTS; i++) begin
      for (int j = 0; j < PORTS; j++) begin
        strb.chainMask[i][j] = (j < i) && reqValid[i] && reqValid[j] &&
                               (reqBase[j] == reqBase[i]);
      end
    end
    for (int b = 0; b < BASES; b++) begin
      for (int j = 0; j < PORTS; j++) begin
        strb.sumMask[b][j] = reqValid[j] && (reqBase[j] == IDX_W'(b));
      end
      strb.wrSel[b] = wrEn && (wrBase == IDX_W'(b));
    end
    strb.rspLoad = reqValid;
  end
endmodule

// File: rtl/mfa_dp.sv
module mfa_dp
  import mfa_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  strobe_t                      strb,
  input  logic [PORTS-1:0][IDX_W-1:0]  reqBase,
  input  logic [PORTS-1:0][DATA_W-1:0] reqInc,
  input  logic [DATA_W-1:0]            wrData,
  output logic [PORTS-1:0]             rspValid,
  output logic [PORTS-1:0][DATA_W-1:0] rspData
);
  logic [BASES-1:0][DATA_W-1:0] baseQ;
  logic [BASES-1:0][DATA_W-1:0] effBase;
  logic [BASES-1:0][DATA_W-1:0] nextBase;
  logic [PORTS-1:0][DATA_W-1:0] portSum;

  for (genvar b = 0; b < BASES; b++) begin : gBase
    assign effBase[b] = strb.wrSel[b] ? wrData : baseQ[b];
    always_comb begin
      logic [DATA_W-1:0] acc;
      acc = effBase[b];
      for (int j = 0; j < PORTS; j++) begin
        if (strb.sumMask[b][j]) acc = acc + reqInc[j];
      end
      nextBase[b] = acc;
    end
  end

  for (genvar i = 0; i < PORTS; i++) begin : gPort
    always_comb begin
      logic [DATA_W-1:0] pre;
      pre = effBase[reqBase[i]];
      for (int j = 0; j < PORTS; j++) begin
        if (strb.chainMask[i][j]) pre = pre + reqInc[j];
      end
      portSum[i] = pre;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseQ    <= '0;
      rspValid <= '0;
      rspData  <= '0;
    end else begin
      baseQ    <= nextBase;
      rspValid <= strb.rspLoad;
      for (int i = 0; i < PORTS; i++) begin
        if (strb.rspLoad[i]) rspData[i] <= portSum[i];
      end
    end
  end
endmodule

// File: rtl/mfa_unit.sv
module mfa_unit
  import mfa_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [PORTS-1:0]        reqValid,
  input  logic [PORTS*IDX_W-1:0]  reqBase,
  input  logic [PORTS*DATA_W-1:0] reqInc,
  input  logic                    wrEn,
  input  logic [IDX_W-1:0]        wrBase,
  input  logic [DATA_W-1:0]       wrData,
  output logic [PORTS-1:0]        rspValid,
  output logic [PORTS*DATA_W-1:0] rspData
);
  logic [PORTS-1:0][IDX_W-1:0]  baseVec;
  logic [PORTS-1:0][DATA_W-1:0] incVec;
  logic [PORTS-1:0][DATA_W-1:0] dataVec;
  strobe_t                      strb;

  assign baseVec = reqBase;
  assign incVec  = reqInc;
  assign rspData = dataVec;

  mfa_ctrl uCtrl (
    .reqValid (reqValid),
    .reqBase  (baseVec),
    .wrEn     (wrEn),
    .wrBase   (wrBase),
    .strb     (strb)
  );

  mfa_dp uDp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .reqBase  (baseVec),
    .reqInc   (incVec),
    .wrData   (wrData),
    .rspValid (rspValid),
    .rspData  (dataVec)
  );
endmodule

// File: rtl/mfa_checker.sv
module mfa_checker
  import mfa_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic [PORTS-1:0]        reqValid,
  input logic [PORTS*IDX_W-1:0]  reqBase,
  input logic [PORTS*DATA_W-1:0] reqInc,
  input logic                    wrEn,
  input logic [IDX_W-1:0]        wrBase,
  input logic [DATA_W-1:0]       wrData,
  input logic [PORTS-1:0]        rspValid,
  input logic [PORTS*DATA_W-1:0] rspData
);
  // R2: fixed latency, no stall
  assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid == $past(reqValid));

  // R7: write wins over the lowest port's read of the same base
  assert_write_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wrEn && reqValid[0] && (reqBase[IDX_W-1:0] == wrBase))
    |-> rspData[DATA_W-1:0] == $past(wrData));

  for (genvar i = 0; i < PORTS - 1; i++) begin : gPair
    // R4: adjacent ports on one base differ by the lower port's increment
    assert_chain_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reqValid[i] && reqValid[i+1] &&
            (reqBase[i*IDX_W +: IDX_W] == reqBase[(i+1)*IDX_W +: IDX_W]))
      |-> rspData[(i+1)*DATA_W +: DATA_W] ==
          DATA_W'(rspData[i*DATA_W +: DATA_W] + $past(reqInc[i*DATA_W +: DATA_W])));
  end

  for (genvar i = 0; i < PORTS; i++) begin : gHold
    // R8: idle port keeps its last result
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(reqValid[i]) |-> $stable(rspData[i*DATA_W +: DATA_W]));
  end
endmodule

bind mfa_unit mfa_checker uChk (.*);

// File: tb/mfa_unit_test.sv
`timescale 1ns/1ps
module mfa_unit_test;
  import mfa_pkg::*;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic [PORTS-1:0]        reqValid = '0;
  logic [PORTS*IDX_W-1:0]  reqBase = '0;
  logic [PORTS*DATA_W-1:0] reqInc = '0;
  logic                    wrEn = 1'b0;
  logic [IDX_W-1:0]        wrBase = '0;
  logic [DATA_W-1:0]       wrData = '0;
  logic [PORTS-1:0]        rspValid;
  logic [PORTS*DATA_W-1:0] rspData;

  int compared = 0;
  int mismatched = 0;
  logic [DATA_W-1:0] model [BASES];
  logic [DATA_W-1:0] lastData [PORTS];

  always #2 clk = ~clk;

  mfa_unit uut (.*);

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic runCycle(input logic [PORTS-1:0] v, input logic [PORTS*IDX_W-1:0] bs,
                          input logic [PORTS*DATA_W-1:0] incs, input logic we,
                          input logic [IDX_W-1:0] wb, input logic [DATA_W-1:0] wd,
                          input string tag);
    logic [DATA_W-1:0] eff [BASES];
    logic [DATA_W-1:0] expd [PORTS];
    for (int b = 0; b < BASES; b++) eff[b] = model[b];
    if (we) eff[wb] = wd;
    for (int i = 0; i < PORTS; i++) begin
      expd[i] = eff[bs[i*IDX_W +: IDX_W]];
      for (int j = 0; j < i; j++)
        if (v[j] && bs[j*IDX_W +: IDX_W] == bs[i*IDX_W +: IDX_W])
          expd[i] = expd[i] + incs[j*DATA_W +: DATA_W];
    end
    for (int j = 0; j < PORTS; j++)
      if (v[j]) eff[bs[j*IDX_W +: IDX_W]] = eff[bs[j*IDX_W +: IDX_W]] + incs[j*DATA_W +: DATA_W];
    reqValid = v; reqBase = bs; reqInc = incs; wrEn = we; wrBase = wb; wrData = wd;
    @(posedge clk); #1;
    check("R2 valid", int'(rspValid), int'(v));
    for (int i = 0; i < PORTS; i++) begin
      if (v[i]) begin
        check(tag, int'(rspData[i*DATA_W +: DATA_W]), int'(expd[i]));
        lastData[i] = expd[i];
      end else begin
        check("R8 hold", int'(rspData[i*DATA_W +: DATA_W]), int'(lastData[i]));
      end
    end
    for (int b = 0; b < BASES; b++) model[b] = eff[b];
    @(negedge clk);
  endtask

  task automatic idle();
    reqValid = '0; wrEn = 1'b0; reqInc = '0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    for (int b = 0; b < BASES; b++) model[b] = '0;
    for (int i = 0; i < PORTS; i++) lastData[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(rspValid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", int'(rspValid), 0);
    // R1: each port reads a different base with zero increment
    runCycle(4'b1111, {2'd3, 2'd2, 2'd1, 2'd0}, '0, 1'b0, '0, '0, "R1 base zero");

    // R3: lone request, then read back
    runCycle(4'b0100, {2'd0, 2'd1, 2'd0, 2'd0}, {16'd0, 16'd5, 16'd0, 16'd0}, 1'b0, '0, '0, "R3 old value");
    runCycle(4'b0001, {2'd0, 2'd0, 2'd0, 2'd1}, '0, 1'b0, '0, '0, "R3 advanced");

    // R10: unit increments give consecutive slots, twice
    runCycle(4'b1111, {4{2'd2}}, {4{16'd1}}, 1'b0, '0, '0, "R10 consecutive");
    runCycle(4'b1111, {4{2'd2}}, {4{16'd1}}, 1'b0, '0, '0, "R10 consecutive again");
    // R5: base 2 holds 8
    runCycle(4'b0010, {4{2'd2}}, '0, 1'b0, '0, '0, "R5 final sum");

    // R6: each port on a distinct base, then read all
    runCycle(4'b1111, {2'd0, 2'd1, 2'd2, 2'd3}, {16'd40, 16'd30, 16'd20, 16'd10}, 1'b0, '0, '0, "R6 independent");
    runCycle(4'b1111, {2'd3, 2'd2, 2'd1, 2'd0}, '0, 1'b0, '0, '0, "R6 readback");

    // R7: write collides with increments on base 3
    runCycle(4'b1010, {2'd3, 2'd0, 2'd3, 2'd0}, {16'd3, 16'd0, 16'd2, 16'd0}, 1'b1, 2'd3, 16'd100, "R7 write first");
    runCycle(4'b0001, {2'd0, 2'd0, 2'd0, 2'd3}, '0, 1'b0, '0, '0, "R7 after collision");
    runCycle(4'b0000, '0, '0, 1'b1, 2'd0, 16'd7, "R7 write alone");
    runCycle(4'b1000, {2'd0, 2'd0, 2'd0, 2'd0}, '0, 1'b0, '0, '0, "R7 write alone readback");

    // R8: invalid ports with nonzero increments leave base 0 alone
    runCycle(4'b0000, {4{2'd0}}, {4{16'h0123}}, 1'b0, '0, '0, "R8 ignored");
    runCycle(4'b0100, {4{2'd0}}, '0, 1'b0, '0, '0, "R8 base unchanged");

    // R9: wrap past the all-ones value
    runCycle(4'b1111, {4{2'd1}}, {4{16'd1}}, 1'b1, 2'd1, 16'hFFFE, "R9 wrap");
    runCycle(4'b0001, {4{2'd1}}, '0, 1'b0, '0, '0, "R9 wrap readback");

    // R4: sweep every base assignment under every valid mask
    for (int bm = 0; bm < 256; bm++) begin
      for (int vm = 0; vm < 16; vm++) begin
        logic [PORTS*DATA_W-1:0] incs;
        for (int i = 0; i < PORTS; i++)
          incs[i*DATA_W +: DATA_W] = DATA_W'((bm * 7 + vm * 3 + i * 13 + 1) & 16'hFF);
        runCycle(PORTS'(vm), (PORTS*IDX_W)'(bm), incs, ((bm + vm) % 5) == 0,
                 IDX_W'(bm % BASES), DATA_W'(bm * vm), "R4 ordered prefix");
      end
    end
    // R5: final readback of all bases after the sweep
    runCycle(4'b1111, {2'd3, 2'd2, 2'd1, 2'd0}, '0, 1'b0, '0, '0, "R5 sweep readback");
    idle();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule